// File: doc/BRIEF.md
# Bit-Level Pipelined Threshold Adder

This block adds two unsigned N-bit operands and returns the (N+1)-bit sum, with the final carry in the top bit. It is built as a row of full-adder cells. Each cell has two register stages of threshold gates. The first stage compares the count of ones among the two operand bits and the incoming carry against the thresholds 1, 2 and 3, which gives three flags. The middle flag is the outgoing carry. The second stage forms the sum bit only from those flags, with weights +1, -1 and +1 against a threshold of 1. It never looks at the operand bits again.

The carry moves one cell per register stage, so the operand bits of cell i first pass through a triangular skew chain i stages deep. The sum bits then pass through a second triangular chain that lines them up on the same output stage. There are N+1 stages after the input register, and the last of them is the output register. A valid bit travels with the data.

Operands enter through a valid/ready interface, and results leave through another. Every register in the block, including the input register, moves together under one enable. That enable is high unless a valid result is waiting and the consumer is not ready. While the enable is low, the pipeline holds still and in_ready is low. With out_ready held high, the block accepts a new operand pair on every clock edge.

Top module: `tadd_pipe`

## Requirements
- R1: During reset and just after it, out_valid is 0 and in_ready is 1.
- R2: Each result equals in_a + in_b as an N+1 bit unsigned value. Bit N of out_sum holds the carry out of bit N-1, and bit 0 has no carry in.
- R3: With out_ready high, a pair accepted at clock edge E shows up with out_valid = 1 right after edge E+N+1.
- R4: With out_ready held high, in_ready stays 1 and a new pair is accepted on every edge. Results come out one per cycle, in the order the pairs were accepted.
- R5: On a cycle where in_valid is 0, in_a and in_b are ignored. Such a cycle produces no result, so the number of results equals the number of accepted pairs.
- R6: A carry travels the full width correctly, for example all-ones + 1 = 2^N and all-ones + all-ones = 2^(N+1) - 2.
- R7: While out_valid is 1 and out_ready is 0, the next cycle still has out_valid = 1 with out_sum unchanged, and in_ready is 0. At all other times in_ready is 1.
- R8: Under any mix of back-pressure and input gaps, every accepted pair yields exactly one result, with none lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every pipeline stage |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair on in_a/in_b is offered |
| in_ready | output | 1 | Block takes the offered pair at this edge |
| in_a | input | N | First operand, unsigned |
| in_b | input | N | Second operand, unsigned |
| out_valid | output | 1 | out_sum holds a result |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_sum | output | N+1 | Sum, bit N is the final carry |

## Verification
Directed carry patterns expose a broken carry link or a misaligned skew depth. These include all-ones plus one, all-ones plus all-ones, top bits only, and alternating bits with and without a ripple. Each of these patterns fails on a different cell if the carry or the skew is wrong. Long back-to-back random streams show that neighbouring operand words never mix in the diagonal skew. A single isolated pair measures the exact latency. Alternating gaps with garbage data show that idle cycles create no results. Random stalls on out_ready, combined with random input gaps, test that results are held, that none are lost and that their order is kept under the global enable.

// File: rtl/tadd_pkg.sv
package tadd_pkg;
  // Threshold gate: weighted input sum compared against theta
  function automatic logic thr_gate(input int weighted, input int theta);
    return (weighted >= theta);
  endfunction
endpackage

// File: rtl/tadd_delay.sv
module tadd_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
    end else if (en) begin
      stg[0] <= d;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/tadd_cell.sv
module tadd_cell
  import tadd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic op_a,
  input  logic op_b,
  input  logic cin,
  output logic cout,
  output logic sum
);
  logic ge1_q, ge2_q, ge3_q;
  int   ones;
  int   wsum;

  // first stage: three threshold gates on the ones count
  always_comb ones = int'(op_a) + int'(op_b) + int'(cin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ge1_q <= 1'b0;
      ge2_q <= 1'b0;
      ge3_q <= 1'b0;
    end else if (en) begin
      ge1_q <= thr_gate(ones, 1);
      ge2_q <= thr_gate(ones, 2);
      ge3_q <= thr_gate(ones, 3);
    end
  end

  // second stage: sum from flags only, weights +1 -1 +1, theta 1
  always_comb wsum = int'(ge1_q) - int'(ge2_q) + int'(ge3_q);

  always_ff @(posedge clk) begin
    if (!rst_n)  sum <= 1'b0;
    else if (en) sum <= thr_gate(wsum, 1);
  end

  assign cout = ge2_q;
endmodule

// File: rtl/tadd_pipe.sv
module tadd_pipe #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N:0]   out_sum
);
  localparam int STAGES = N + 1;

  logic         adv;
  logic [N-1:0] a_r, b_r;
  logic         v_r;
  logic [N:0]   carry;
  logic [N-1:0] s_raw;

  assign adv      = out_ready | ~out_valid;
  assign in_ready = adv;
  assign carry[0] = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r <= '0;
      b_r <= '0;
      v_r <= 1'b0;
    end else if (adv) begin
      a_r <= in_a;
      b_r <= in_b;
      v_r <= in_valid;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [1:0] ab_sk;

    if (i == 0) begin : g_noskew
      assign ab_sk = {a_r[0], b_r[0]};
    end else begin : g_skew
      tadd_delay #(.W(2), .DEPTH(i)) u_skew (
        .clk(clk), .rst_n(rst_n), .en(adv),
        .d({a_r[i], b_r[i]}), .q(ab_sk)
      );
    end

    tadd_cell u_cell (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .op_a(ab_sk[1]), .op_b(ab_sk[0]), .cin(carry[i]),
      .cout(carry[i+1]), .sum(s_raw[i])
    );

    if (i == N - 1) begin : g_nodeskew
      assign out_sum[i] = s_raw[i];
    end else begin : g_deskew
      tadd_delay #(.W(1), .DEPTH(N - 1 - i)) u_deskew (
        .clk(clk), .rst_n(rst_n), .en(adv),
        .d(s_raw[i]), .q(out_sum[i])
      );
    end
  end

  tadd_delay #(.W(1), .DEPTH(1)) u_cy_deskew (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .d(carry[N]), .q(out_sum[N])
  );

  tadd_delay #(.W(1), .DEPTH(STAGES)) u_valid (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .d(v_r), .q(out_valid)
  );
endmodule

// File: rtl/tadd_pipe_chk.sv
module tadd_pipe_chk #(
  parameter int N = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [N:0] out_sum
);
  localparam int OCC_MAX = N + 2;
  int occ;
  int cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= 0;
      cyc <= 0;
    end else begin
      occ <= occ + int'(in_valid && in_ready) - int'(out_valid && out_ready);
      if (cyc < OCC_MAX + 1) cyc <= cyc + 1;
    end
  end

  // R7: a stalled result is held
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  // R8: outstanding pairs never exceed pipeline capacity
  p_occ_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_MAX);

  // R8: no result without an accepted pair
  p_valid_needs_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ > 0);

  // R3: no result appears before the pipeline depth has elapsed
  p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cyc >= N + 2);
endmodule

bind tadd_pipe tadd_pipe_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum)
);

// File: tb/tadd_pipe_tb.sv
module tadd_pipe_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [N-1:0] in_a = '0;
  logic [N-1:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [N:0]   out_sum;

  int n_tests = 0;
  int n_fail  = 0;
  int out_cnt = 0;
  string cur_tag = "R2";
  logic [N:0] exp_q[$];
  bit         stall_prev = 1'b0;
  logic [N:0] held = '0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  tadd_pipe #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        chk(out_valid === 1'b1 && out_sum === held, "R7", "stalled output held",
            {out_valid, 23'b0, out_sum}, {1'b1, 23'b0, held});
      end
      chk(in_ready === !(out_valid && !out_ready), "R7", "in_ready rule",
          32'(in_ready), 32'(!(out_valid && !out_ready)));
      stall_prev = out_valid && !out_ready;
      held = out_sum;
      if (out_valid && out_ready) begin
        out_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "result with no pending pair", 32'(out_sum), 32'h0);
        end else begin
          logic [N:0] e;
          e = exp_q.pop_front();
          chk(out_sum === e, cur_tag, "sum", 32'(out_sum), 32'(e));
        end
      end
      if (in_valid && in_ready) exp_q.push_back({1'b0, in_a} + {1'b0, in_b});
    end
  end

  // one cycle: drive just after the rising edge, report acceptance
  task automatic cycle(input bit v, input logic [N-1:0] a, input logic [N-1:0] b,
                       input bit rdy, output bit acc);
    in_valid  = v;
    in_a      = a;
    in_b      = b;
    out_ready = rdy;
    @(negedge clk);
    acc = v && in_ready;
    @(posedge clk);
    #1;
  endtask

  task automatic drain(input string tag);
    bit acc;
    for (int k = 0; k < 100 && exp_q.size() != 0; k++) cycle(1'b0, '0, '0, 1'b1, acc);
    cycle(1'b0, '0, '0, 1'b1, acc);
    chk(exp_q.size() == 0, tag, "all pairs delivered", 32'(exp_q.size()), 32'h0);
  endtask

  task automatic t_reset;
    chk(out_valid === 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);
    chk(in_ready === 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'h1);
  endtask

  task automatic t_latency;
    bit acc;
    int lat;
    cur_tag = "R2";
    cycle(1'b1, 8'd3, 8'd4, 1'b1, acc);   // accepted at this edge
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(posedge clk);
      #1;
      lat++;
    end
    chk(lat == N + 1, "R3", "latency in edges", 32'(lat), 32'(N + 1));
    drain("R3");
  endtask

  task automatic t_carry;
    bit acc;
    logic [N-1:0] av[8] = '{8'hFF, 8'hFF, 8'h00, 8'h80, 8'h55, 8'hAA, 8'h7F, 8'h01};
    logic [N-1:0] bv[8] = '{8'h01, 8'hFF, 8'h00, 8'h80, 8'hAA, 8'h56, 8'h01, 8'hFF};
    cur_tag = "R6";
    foreach (av[k]) cycle(1'b1, av[k], bv[k], 1'b1, acc);
    drain("R6");
  endtask

  task automatic t_stream;
    bit acc;
    int base, okacc;
    cur_tag = "R4";
    base  = out_cnt;
    okacc = 0;
    for (int k = 0; k < 200; k++) begin
      cycle(1'b1, N'($urandom), N'($urandom), 1'b1, acc);
      okacc += int'(acc);
    end
    chk(okacc == 200, "R4", "every cycle accepted", 32'(okacc), 32'd200);
    drain("R4");
    chk(out_cnt - base == 200, "R4", "result count", 32'(out_cnt - base), 32'd200);
  endtask

  task automatic t_bubble;
    bit acc;
    int base;
    cur_tag = "R5";
    base = out_cnt;
    for (int k = 0; k < 40; k++) cycle(k % 2 == 0, N'($urandom), N'($urandom), 1'b1, acc);
    drain("R5");
    chk(out_cnt - base == 20, "R5", "idle cycles give no result", 32'(out_cnt - base), 32'd20);
  endtask

  task automatic t_backpress;
    bit acc;
    int base, nacc;
    cur_tag = "R8";
    base = out_cnt;
    nacc = 0;
    for (int k = 0; k < 300; k++) begin
      cycle($urandom_range(0, 3) != 0, N'($urandom), N'($urandom),
            $urandom_range(0, 2) != 0, acc);
      nacc += int'(acc);
    end
    drain("R8");
    chk(out_cnt - base == nacc, "R8", "one result per accepted pair",
        32'(out_cnt - base), 32'(nacc));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_latency();
    t_carry();
    t_stream();
    t_bubble();
    t_backpress();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule